// File: doc/BRIEF.md
# Video Pixel Bus Formatter

This block sits at the entry of a video pipeline. It receives a 36-bit parallel pixel bus made of three 12-bit channels. A 3-bit order control can permute those channels, and a 5-bit format code tells the block how component samples are packed on the permuted bus. It then delivers luma and chroma, or three 4:4:4 components, on 12-bit outputs. A valid strobe marks each output, and everything is in the pixel-clock domain.

Three packings are handled:

- **Single-bus SDR 4:2:2.** Luma and chroma words alternate on one channel.
- **Three-bus SDR 4:4:4.** One component comes from each channel.
- **Single-bus DDR 4:2:2.** The two halves of a pixel arrive on opposite clock edges.

Narrower components are read from the upper bits of their channel. They are delivered MSB-aligned with zero low bits.

In DDR operation, two controls set how the halves are paired and named. One sets the capture edge order, that is, whether a pixel starts on the rising or the falling edge. The other swaps which half is luma and which is chroma. Chroma outputs carry a Cb/Cr flag that alternates pixel by pixel.

Top module: `vid_pix_formatter`

## Requirements
- R1: The channels are top = bits 35:24, middle = 23:12 and bottom = 11:0. The order code maps sources into positions (top, middle, bottom) as follows: 000, 010 and 111 give (T,M,B); 001 gives (T,B,M); 011 gives (M,T,B); 100 gives (B,T,M); 101 gives (B,M,T); 110 gives (M,B,T). The permutation is applied before any extraction.
- R2: Format codes 6, 7 and 8 are three-bus 4:4:4 with 8, 10 and 12 bits per component. `comp0_out`, `comp1_out` and `comp2_out` take the permuted top, middle and bottom channels. Each keeps the top 8, 10 or 12 bits of its channel with the remaining low bits zero. The result appears one clock after the rising edge that samples the bus, with `vld_out` high every cycle.
- R3: Format codes 0, 1 and 2 are single-bus SDR 4:2:2 of 8, 10 and 12 bits, carried on the permuted top channel as a luma word followed by a chroma word. After the rising edge that samples the chroma word, `comp0_out` holds the luma and `comp1_out` holds the chroma, with `vld_out` high. `vld_out` is never high on two successive cycles.
- R4: Format codes 9, 10 and 11 are single-bus DDR 4:2:2 of 8, 10 and 12 bits on the permuted top channel. With `fall_first` = 0 and `yc_swap` = 0, a pixel is the rising-edge sample followed by the next falling-edge sample. The rising-edge sample is luma and the falling-edge sample is chroma. The pair is output at the following rising edge, so one pixel is delivered per cycle.
- R5: With `yc_swap` = 1 in DDR mode, the luma and chroma roles of the two halves of each pixel are exchanged.
- R6: With `fall_first` = 1 in DDR mode, a pixel is the falling-edge sample followed by the next rising-edge sample. The pair is output at that rising edge, and the first half is luma unless `yc_swap` = 1.
- R7: In 4:2:2 modes, `cr_out` is 0 for Cb and 1 for Cr. It starts at Cb after reset or after any change of format code, and toggles on each valid pixel. The first rising edge after such a change produces no valid output.
- R8: Format codes outside 0–2, 6–11 hold `vld_out` low. Whenever `vld_out` is low, all component outputs and `cr_out` are zero.
- R9: While `rst_n` is low, `vld_out`, `cr_out` and all component outputs are zero.
- R10: In 4:2:2 modes, `comp2_out` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; both edges are used in DDR modes |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_bus | input | 36 | Parallel pixel bus, three 12-bit channels |
| fmt_sel | input | 5 | Bus format code |
| chan_order | input | 3 | Channel permutation code |
| yc_swap | input | 1 | DDR: exchange luma/chroma roles of the two halves |
| fall_first | input | 1 | DDR: pixel starts on the falling edge |
| comp0_out | output | 12 | Luma, or first 4:4:4 component |
| comp1_out | output | 12 | Chroma, or second 4:4:4 component |
| comp2_out | output | 12 | Third 4:4:4 component, zero in 4:2:2 |
| cr_out | output | 1 | Chroma type: 0 = Cb, 1 = Cr |
| vld_out | output | 1 | Output sample valid |

## Verification
Some properties are checked on every cycle. Unsupported codes never yield valid data, and idle outputs are all zero. Zero low bits are enforced in 8-bit 4:4:4. The third output stays empty in 4:2:2, SDR 4:2:2 never produces two valid cycles back to back, and no valid output follows a change of format. Other behaviours can only be shown by the bench scenarios, because they depend on the data values: the permutation for each order code, the pairing of rising and falling half-samples under both edge orders and both luma/chroma orders, and the Cb/Cr sequence.

// File: rtl/vpf_pkg.sv
package vpf_pkg;

    localparam int FMT_W = 5;
    localparam int ORD_W = 3;
    localparam int NARROW_W = 8;
    localparam int MID_W = 10;

    typedef enum logic [1:0] {
        FK_NONE,
        FK_SDR1,
        FK_444,
        FK_DDR1
    } fmt_kind_e;

    function automatic fmt_kind_e fmt_kind(input logic [FMT_W-1:0] code);
        fmt_kind_e k;
        case (code)
            5'd0, 5'd1, 5'd2:   k = FK_SDR1;
            5'd6, 5'd7, 5'd8:   k = FK_444;
            5'd9, 5'd10, 5'd11: k = FK_DDR1;
            default:            k = FK_NONE;
        endcase
        return k;
    endfunction

    // Component width implied by a code: 8, 10 or full channel width
    function automatic int fmt_width(input logic [FMT_W-1:0] code, input int full_w);
        int w;
        case (code)
            5'd0, 5'd6, 5'd9:  w = NARROW_W;
            5'd1, 5'd7, 5'd10: w = MID_W;
            default:           w = full_w;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/vpf_chan_swap.sv
module vpf_chan_swap #(
    parameter int CH_W = 12
) (
    input  logic [3*CH_W-1:0] bus_in,
    input  logic [2:0]        order,
    output logic [3*CH_W-1:0] bus_out
);
    // index 0 = top, 1 = middle, 2 = bottom
    logic [CH_W-1:0] src [3];
    logic [1:0]      pick [3];

    for (genvar g = 0; g < 3; g++) begin : g_unpack
        assign src[g] = bus_in[(3-g)*CH_W-1 -: CH_W];
        assign bus_out[(3-g)*CH_W-1 -: CH_W] = src[pick[g]];
    end

    always_comb begin
        case (order)
            3'b001:  begin pick[0] = 2'd0; pick[1] = 2'd2; pick[2] = 2'd1; end
            3'b011:  begin pick[0] = 2'd1; pick[1] = 2'd0; pick[2] = 2'd2; end
            3'b100:  begin pick[0] = 2'd2; pick[1] = 2'd0; pick[2] = 2'd1; end
            3'b101:  begin pick[0] = 2'd2; pick[1] = 2'd1; pick[2] = 2'd0; end
            3'b110:  begin pick[0] = 2'd1; pick[1] = 2'd2; pick[2] = 2'd0; end
            default: begin pick[0] = 2'd0; pick[1] = 2'd1; pick[2] = 2'd2; end
        endcase
    end
endmodule

// File: rtl/vpf_neg_capture.sv
module vpf_neg_capture #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/vid_pix_formatter.sv
module vid_pix_formatter
    import vpf_pkg::*;
#(
    parameter int CH_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3*CH_W-1:0] pix_bus,
    input  logic [4:0]        fmt_sel,
    input  logic [2:0]        chan_order,
    input  logic              yc_swap,
    input  logic              fall_first,
    output logic [CH_W-1:0]   comp0_out,
    output logic [CH_W-1:0]   comp1_out,
    output logic [CH_W-1:0]   comp2_out,
    output logic              cr_out,
    output logic              vld_out
);
    localparam int BUS_W = 3 * CH_W;

    typedef struct packed {
        logic             phase;
        logic             crsel;
        logic [CH_W-1:0]  hold;
        logic [FMT_W-1:0] fmt;
        logic [CH_W-1:0]  c0;
        logic [CH_W-1:0]  c1;
        logic [CH_W-1:0]  c2;
        logic             cr;
        logic             vld;
    } st_t;

    st_t st_d, st_q;

    logic [BUS_W-1:0] perm_bus;
    logic [CH_W-1:0]  neg_raw;

    vpf_chan_swap #(.CH_W(CH_W)) swap_i (
        .bus_in  (pix_bus),
        .order   (chan_order),
        .bus_out (perm_bus)
    );

    vpf_neg_capture #(.W(CH_W)) negcap_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (perm_bus[BUS_W-1 -: CH_W]),
        .q     (neg_raw)
    );

    fmt_kind_e       kind;
    logic [CH_W-1:0] mask;
    logic [CH_W-1:0] top_m, mid_m, bot_m, neg_m;
    logic [CH_W-1:0] first_h, second_h;
    logic            restart, ph, crs;

    always_comb begin
        kind    = fmt_kind(fmt_sel);
        mask    = {CH_W{1'b1}} << (CH_W - fmt_width(fmt_sel, CH_W));
        top_m   = perm_bus[BUS_W-1 -: CH_W] & mask;
        mid_m   = perm_bus[2*CH_W-1 -: CH_W] & mask;
        bot_m   = perm_bus[CH_W-1:0] & mask;
        neg_m   = neg_raw & mask;
        restart = (fmt_sel != st_q.fmt);
        ph      = restart ? 1'b0 : st_q.phase;
        crs     = restart ? 1'b0 : st_q.crsel;

        first_h  = fall_first ? neg_m : st_q.hold;
        second_h = fall_first ? top_m : neg_m;

        st_d       = st_q;
        st_d.fmt   = fmt_sel;
        st_d.phase = ph;
        st_d.crsel = crs;
        st_d.c0    = '0;
        st_d.c1    = '0;
        st_d.c2    = '0;
        st_d.cr    = 1'b0;
        st_d.vld   = 1'b0;

        case (kind)
            FK_444: begin
                st_d.c0    = top_m;
                st_d.c1    = mid_m;
                st_d.c2    = bot_m;
                st_d.vld   = 1'b1;
                st_d.phase = 1'b0;
                st_d.crsel = 1'b0;
            end
            FK_SDR1: begin
                if (!ph) begin
                    st_d.hold  = top_m;
                    st_d.phase = 1'b1;
                end else begin
                    st_d.c0    = st_q.hold;
                    st_d.c1    = top_m;
                    st_d.cr    = crs;
                    st_d.vld   = 1'b1;
                    st_d.crsel = ~crs;
                    st_d.phase = 1'b0;
                end
            end
            FK_DDR1: begin
                st_d.hold  = top_m;
                st_d.phase = 1'b1;
                if (ph) begin
                    st_d.c0    = yc_swap ? second_h : first_h;
                    st_d.c1    = yc_swap ? first_h : second_h;
                    st_d.cr    = crs;
                    st_d.vld   = 1'b1;
                    st_d.crsel = ~crs;
                end
            end
            default: begin
                st_d.phase = 1'b0;
                st_d.crsel = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign comp0_out = st_q.c0;
    assign comp1_out = st_q.c1;
    assign comp2_out = st_q.c2;
    assign cr_out    = st_q.cr;
    assign vld_out   = st_q.vld;

endmodule

// File: rtl/vpf_chk.sv
module vpf_chk
    import vpf_pkg::*;
#(
    parameter int CH_W = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic [4:0]      fmt_sel,
    input logic [CH_W-1:0] comp0_out,
    input logic [CH_W-1:0] comp1_out,
    input logic [CH_W-1:0] comp2_out,
    input logic            cr_out,
    input logic            vld_out
);
    localparam logic [CH_W-1:0] LOW_MASK = ~({CH_W{1'b1}} << (CH_W - NARROW_W));

    // R8
    unsupported_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_kind(fmt_sel) == FK_NONE) |=> !vld_out);

    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_out |-> (comp0_out == '0 && comp1_out == '0 && comp2_out == '0 && !cr_out));

    // R2
    narrow_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_sel == 5'd6) |=> ((comp0_out & LOW_MASK) == '0 && (comp1_out & LOW_MASK) == '0
                               && (comp2_out & LOW_MASK) == '0));

    // R10
    third_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_kind(fmt_sel) == FK_SDR1 || fmt_kind(fmt_sel) == FK_DDR1) |=> (comp2_out == '0));

    // R3
    sdr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_out && fmt_kind(fmt_sel) == FK_SDR1) |=> !vld_out);

    // R7
    restart_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_sel != $past(fmt_sel) && fmt_kind(fmt_sel) != FK_444) |=> !vld_out);

endmodule

bind vid_pix_formatter vpf_chk #(.CH_W(CH_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .fmt_sel   (fmt_sel),
    .comp0_out (comp0_out),
    .comp1_out (comp1_out),
    .comp2_out (comp2_out),
    .cr_out    (cr_out),
    .vld_out   (vld_out)
);

// File: tb/vid_pix_formatter_tb_top.sv
module vid_pix_formatter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [35:0] pix_bus = '0;
    logic [4:0]  fmt_sel = 5'h1F;
    logic [2:0]  chan_order = '0;
    logic        yc_swap = 1'b0;
    logic        fall_first = 1'b0;
    logic [11:0] comp0_out, comp1_out, comp2_out;
    logic        cr_out, vld_out;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    vid_pix_formatter dut_i (
        .clk(clk), .rst_n(rst_n), .pix_bus(pix_bus), .fmt_sel(fmt_sel),
        .chan_order(chan_order), .yc_swap(yc_swap), .fall_first(fall_first),
        .comp0_out(comp0_out), .comp1_out(comp1_out), .comp2_out(comp2_out),
        .cr_out(cr_out), .vld_out(vld_out)
    );

    // {fmt[44:40], order[39:37], valid[36], c0, c1, c2}; bus = {A5F, 3C7, 6E9}
    localparam logic [44:0] VEC [14] = '{
        {5'd8, 3'd0, 1'b1, 12'hA5F, 12'h3C7, 12'h6E9},
        {5'd8, 3'd1, 1'b1, 12'hA5F, 12'h6E9, 12'h3C7},
        {5'd8, 3'd2, 1'b1, 12'hA5F, 12'h3C7, 12'h6E9},
        {5'd8, 3'd3, 1'b1, 12'h3C7, 12'hA5F, 12'h6E9},
        {5'd8, 3'd4, 1'b1, 12'h6E9, 12'hA5F, 12'h3C7},
        {5'd8, 3'd5, 1'b1, 12'h6E9, 12'h3C7, 12'hA5F},
        {5'd8, 3'd6, 1'b1, 12'h3C7, 12'h6E9, 12'hA5F},
        {5'd8, 3'd7, 1'b1, 12'hA5F, 12'h3C7, 12'h6E9},
        {5'd6, 3'd0, 1'b1, 12'hA50, 12'h3C0, 12'h6E0},
        {5'd7, 3'd0, 1'b1, 12'hA5C, 12'h3C4, 12'h6E8},
        {5'd7, 3'd5, 1'b1, 12'h6E8, 12'h3C4, 12'hA5C},
        {5'd6, 3'd3, 1'b1, 12'h3C0, 12'hA50, 12'h6E0},
        {5'd3, 3'd0, 1'b0, 12'h000, 12'h000, 12'h000},
        {5'h13, 3'd0, 1'b0, 12'h000, 12'h000, 12'h000}
    };

    task automatic chk(input string req, input logic [37:0] act, input logic [37:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [37:0] outs();
        return {vld_out, cr_out, comp0_out, comp1_out, comp2_out};
    endfunction

    function automatic logic [11:0] mask_of(input logic [4:0] f);
        case (f)
            5'd0, 5'd6, 5'd9:  return 12'hFF0;
            5'd1, 5'd7, 5'd10: return 12'hFFC;
            default:           return 12'hFFF;
        endcase
    endfunction

    // Places v in the source channel that the order code moves to the top position
    function automatic logic [35:0] place(input logic [2:0] ord, input logic [11:0] v);
        if (ord == 3'd3 || ord == 3'd6) return {12'h5A5, v, 12'h5A5};
        if (ord == 3'd4 || ord == 3'd5) return {12'h5A5, 12'h5A5, v};
        return {v, 12'h5A5, 12'h5A5};
    endfunction

    // Called at a falling edge; returns at the next falling edge
    task automatic ddr_word(input logic [2:0] ord, input logic [11:0] r, input logic [11:0] f);
        #5 pix_bus = place(ord, r);
        @(posedge clk);
        #5 pix_bus = place(ord, f);
        @(negedge clk);
    endtask

    task automatic run_ddr(input string req, input logic [4:0] f, input logic ff,
                           input logic ys, input logic [2:0] ord);
        logic [11:0] rv [5];
        logic [11:0] fv [5];
        logic [11:0] m, first_h, second_h, y, c;
        m = mask_of(f);
        for (int i = 0; i < 5; i++) begin
            rv[i] = 12'h1A3 + 12'(i * 12'h111);
            fv[i] = 12'hE5D - 12'(i * 12'h101);
        end
        fmt_sel = 5'd6;
        @(negedge clk);
        fmt_sel = f;
        fall_first = ff;
        yc_swap = ys;
        chan_order = ord;
        for (int k = 0; k < 5; k++) begin
            ddr_word(ord, rv[k], fv[k]);
            if (k == 0) begin
                chk({req, " R7 first edge after format change"}, outs(), 38'd0);
            end else begin
                first_h  = ff ? fv[k-1] : rv[k-1];
                second_h = ff ? rv[k] : fv[k-1];
                y = (ys ? second_h : first_h) & m;
                c = (ys ? first_h : second_h) & m;
                chk({req, " R7 R10 DDR pair"}, outs(), {1'b1, 1'((k - 1) % 2), y, c, 12'h000});
            end
        end
    endtask

    initial begin
        #4_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog R9 actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        chk("R9 reset", outs(), 38'd0);
        rst_n = 1'b1;
        pix_bus = {12'hA5F, 12'h3C7, 12'h6E9};

        // R1 R2 R8: table walk
        for (int i = 0; i < 14; i++) begin
            fmt_sel = VEC[i][44:40];
            chan_order = VEC[i][39:37];
            @(negedge clk);
            chk((VEC[i][36] ? "R1 R2 table" : "R8 table"), outs(),
                {VEC[i][36], 1'b0, VEC[i][35:0]});
        end

        // R3 R7 R10: single-bus SDR, 10-bit, pixel 1 then pixel 2
        fmt_sel = 5'd1;
        chan_order = 3'd0;
        pix_bus = {12'hABF, 12'h111, 12'h222};
        @(negedge clk);
        chk("R3 R7 luma word", outs(), 38'd0);
        pix_bus = {12'h7F3, 12'h111, 12'h222};
        @(negedge clk);
        chk("R3 pair 1", outs(), {1'b1, 1'b0, 12'hABC, 12'h7F0, 12'h000});
        pix_bus = {12'h4E2, 12'h333, 12'h444};
        @(negedge clk);
        chk("R3 gap", outs(), 38'd0);
        pix_bus = {12'h0FF, 12'h333, 12'h444};
        @(negedge clk);
        chk("R3 R7 pair 2 Cr", outs(), {1'b1, 1'b1, 12'h4E0, 12'h0FC, 12'h000});

        // R4, R5, R6: DDR variants
        run_ddr("R4", 5'd11, 1'b0, 1'b0, 3'd0);
        run_ddr("R5", 5'd11, 1'b0, 1'b1, 3'd3);
        run_ddr("R6", 5'd9, 1'b1, 1'b0, 3'd4);
        run_ddr("R6 R5", 5'd10, 1'b1, 1'b1, 3'd0);

        // R8: unsupported code after DDR
        fmt_sel = 5'd4;
        @(negedge clk);
        chk("R8 unsupported", outs(), 38'd0);

        // R9: reset mid-stream
        fmt_sel = 5'd8;
        @(negedge clk);
        rst_n = 1'b0;
        #1 chk("R9 async reset", outs(), 38'd0);
        @(negedge clk);
        rst_n = 1'b1;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule